// File: doc/BRIEF.md
# Per-Pixel Fragment Capture and Depth-Ordered Resolve

This block gathers the fragments that land on each pixel of a small tile, and later returns them to a compositor sorted by depth. The block runs in two phases.

During capture, every accepted fragment takes the next free slot of its pixel. The slot index is the pixel's fragment count, which is read and advanced in the same clock cycle. Fragments are therefore stored in arrival order, and they are not compared with one another while they are stored.

During resolve, a sequencer visits the pixels in address order. For each pixel it copies the occupied slots into a local register file and sorts them with a serial insertion sort. It then streams them out nearest first, one beat per cycle, so that a downstream unit can blend front to back.

A pixel that receives more fragments than it has slots keeps its first fragments, drops the later ones, and raises a sticky overflow mark that travels with its output beats. The clear pulse zeroes all counts and overflow marks before a new capture begins. A resolve reads the stored lists and leaves them unchanged, so the same contents can be resolved again.

Top module: `frag_sort_top`

## Requirements
- R1: A cycle with `clr` high, while the block is not busy, sets every pixel's count to zero and clears every overflow mark. A `frag_valid` in that same cycle is dropped.
- R2: An accepted fragment (`frag_valid` high, `clr` low, not busy) for a pixel that holds fewer than SLOTS fragments is stored in slot number equal to the pixel's count, and the count rises by one.
- R3: When a pixel already holds SLOTS fragments, further fragments for it are dropped, its count stays at SLOTS, and every output beat of that pixel carries `out_ovf` = 1 until the next clear.
- R4: A pulse on `resolve_start` while idle makes the block visit pixels 0 to NPIX-1 in increasing address order and emit exactly as many beats per pixel as the pixel holds. A pixel with no fragments emits no beat.
- R5: Within one pixel, beats leave in non-decreasing unsigned order of `out_depth`, so the nearest fragment comes first.
- R6: Fragments of one pixel with equal depth leave in the order in which they were captured.
- R7: On each beat, `out_pix` is the pixel address and `out_rank` counts 0, 1, 2 and so on within the pixel. `out_last` is 1 only on the pixel's final beat.
- R8: `busy` is 1 from the cycle after an accepted `resolve_start` until the final beat has been emitted. While `busy` is 1, `frag_valid`, `clr` and `resolve_start` have no effect, and a resolve leaves the stored lists intact.
- R9: Fragments for the same pixel in consecutive cycles each receive a distinct, successive slot, and none is lost or overwritten.
- R10: After reset, `busy` and `out_valid` are 0 and every pixel is empty with no overflow mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear all pixel counts and overflow marks |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_pix | input | $clog2(NPIX) | Pixel address of the fragment |
| frag_depth | input | DEPTH_W | Unsigned depth key of the fragment |
| frag_color | input | COLOR_W | Colour word of the fragment |
| resolve_start | input | 1 | Start the sorted readout of all pixels |
| busy | output | 1 | Resolve in progress |
| out_valid | output | 1 | Output beat present |
| out_pix | output | $clog2(NPIX) | Pixel address of the beat |
| out_rank | output | $clog2(SLOTS) | Position of the beat in sorted order |
| out_depth | output | DEPTH_W | Depth of the beat |
| out_color | output | COLOR_W | Colour of the beat |
| out_last | output | 1 | Final beat of this pixel |
| out_ovf | output | 1 | This pixel dropped fragments |

## Verification
Depth lists are driven in several orders: descending, already ascending, interleaved, and with every depth equal. Descending order makes the sort do its full number of swaps. Ascending order shows that no swap is made when none is needed. Equal depths with distinct colours show whether the sort keeps capture order.

Back-to-back fragments to one pixel, including a run beyond the slot capacity, separate a correct one-cycle count update from lost or overwritten slots, and they exercise the overflow mark. Fragments and clear pulses injected while a resolve is running, followed by a second resolve of the same contents, show that the busy phase blocks them and that readout does not consume the lists. The first and last pixel addresses are included, and most pixels stay empty.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam int DEPTH_W = 16;
    localparam int COLOR_W = 16;

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic [COLOR_W-1:0] color;
    } frag_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_LOAD,
        RS_SORT,
        RS_EMIT
    } rs_state_t;

    // strict comparison keeps equal keys in capture order
    function automatic logic deeper(input logic [DEPTH_W-1:0] a, input logic [DEPTH_W-1:0] b);
        return a > b;
    endfunction
endpackage

// File: rtl/fs_slot_store.sv
module fs_slot_store import fs_pkg::*; #(
    parameter int NPIX  = 16,
    parameter int SLOTS = 4,
    localparam int PIX_W = $clog2(NPIX),
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic             clr,
    input  logic             wr_valid,
    input  logic [PIX_W-1:0] wr_pix,
    input  frag_t            wr_frag,
    input  logic [PIX_W-1:0] rd_pix,
    output logic [CNT_W-1:0] rd_cnt,
    output logic             rd_ovf,
    output frag_t            rd_row [SLOTS]
);
    logic [CNT_W-1:0] cnt_q [NPIX];
    logic             ovf_q [NPIX];
    frag_t            slot_q [NPIX][SLOTS];

    logic clr_en;
    logic wr_en;
    logic has_room;

    assign clr_en   = clr && !lock;
    assign wr_en    = wr_valid && !clr && !lock;
    assign has_room = cnt_q[wr_pix] < CNT_W'(SLOTS);

    // counter read-modify-write in a single cycle: the next fragment sees the new count
    always_ff @(posedge clk) begin
        if (rst || clr_en) begin
            for (int p = 0; p < NPIX; p++) begin
                cnt_q[p] <= '0;
                ovf_q[p] <= 1'b0;
            end
        end else if (wr_en) begin
            if (has_room) cnt_q[wr_pix] <= cnt_q[wr_pix] + CNT_W'(1);
            else          ovf_q[wr_pix] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && has_room)
            slot_q[wr_pix][cnt_q[wr_pix][IDX_W-1:0]] <= wr_frag;
    end

    assign rd_cnt = cnt_q[rd_pix];
    assign rd_ovf = ovf_q[rd_pix];
    always_comb begin
        for (int s = 0; s < SLOTS; s++) rd_row[s] = slot_q[rd_pix][s];
    end

    for (genvar g = 0; g < NPIX; g++) begin : g_chk
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] <= CNT_W'(SLOTS)); // R3
        AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_pix == PIX_W'(g) && cnt_q[g] < CNT_W'(SLOTS))
            |=> cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)); // R9
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ovf_q[g] && !clr_en) |=> ovf_q[g]); // R3
        AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
            clr_en |=> (cnt_q[g] == '0 && !ovf_q[g])); // R1
        AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
            lock |=> $stable(cnt_q[g])); // R8
    end
endmodule

// File: rtl/fs_resolver.sv
module fs_resolver import fs_pkg::*; #(
    parameter int NPIX  = 16,
    parameter int SLOTS = 4,
    localparam int PIX_W = $clog2(NPIX),
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [PIX_W-1:0]   rd_pix,
    input  logic [CNT_W-1:0]   rd_cnt,
    input  logic               rd_ovf,
    input  frag_t              rd_row [SLOTS],
    output logic               busy,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_pix,
    output logic [IDX_W-1:0]   out_rank,
    output logic [DEPTH_W-1:0] out_depth,
    output logic [COLOR_W-1:0] out_color,
    output logic               out_last,
    output logic               out_ovf
);
    rs_state_t        state;
    logic [PIX_W-1:0] pix;
    frag_t            loc [SLOTS];
    logic [CNT_W-1:0] n;
    logic [IDX_W-1:0] i, j, k;
    logic             ovf;
    logic             last_pix;
    logic             do_swap;
    logic             k_final;

    assign last_pix = pix == PIX_W'(NPIX - 1);
    assign do_swap  = (j != '0) && deeper(loc[j - IDX_W'(1)].depth, loc[j].depth);
    assign k_final  = (CNT_W'(k) + CNT_W'(1)) == n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
            pix   <= '0;
            n     <= '0;
            i     <= '0;
            j     <= '0;
            k     <= '0;
            ovf   <= 1'b0;
        end else begin
            case (state)
                RS_IDLE: if (start) begin
                    pix   <= '0;
                    state <= RS_LOAD;
                end
                RS_LOAD: begin
                    if (rd_cnt == '0) begin
                        if (last_pix) state <= RS_IDLE;
                        else          pix   <= pix + PIX_W'(1);
                    end else begin
                        for (int s = 0; s < SLOTS; s++) loc[s] <= rd_row[s];
                        n     <= rd_cnt;
                        ovf   <= rd_ovf;
                        i     <= IDX_W'(1);
                        j     <= IDX_W'(1);
                        k     <= '0;
                        state <= (rd_cnt == CNT_W'(1)) ? RS_EMIT : RS_SORT;
                    end
                end
                RS_SORT: begin
                    if (do_swap) begin
                        loc[j - IDX_W'(1)] <= loc[j];
                        loc[j]             <= loc[j - IDX_W'(1)];
                        j                  <= j - IDX_W'(1);
                    end else if ((CNT_W'(i) + CNT_W'(1)) >= n) begin
                        state <= RS_EMIT;
                    end else begin
                        i <= i + IDX_W'(1);
                        j <= i + IDX_W'(1);
                    end
                end
                RS_EMIT: begin
                    if (k_final) begin
                        if (last_pix) state <= RS_IDLE;
                        else begin
                            pix   <= pix + PIX_W'(1);
                            state <= RS_LOAD;
                        end
                    end else begin
                        k <= k + IDX_W'(1);
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    assign rd_pix    = pix;
    assign busy      = state != RS_IDLE;
    assign out_valid = state == RS_EMIT;
    assign out_pix   = pix;
    assign out_rank  = k;
    assign out_depth = loc[k].depth;
    assign out_color = loc[k].color;
    assign out_last  = out_valid && k_final;
    assign out_ovf   = ovf;

    AST_DEPTH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (out_valid && !deeper($past(out_depth), out_depth))); // R5
    AST_RANK_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (out_rank == $past(out_rank) + IDX_W'(1))); // R7
    AST_RANK_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_rank == '0); // R7
    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> $stable(out_pix)); // R4
endmodule

// File: rtl/frag_sort_top.sv
module frag_sort_top import fs_pkg::*; #(
    parameter int NPIX  = 16,
    parameter int SLOTS = 4,
    localparam int PIX_W = $clog2(NPIX),
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               frag_valid,
    input  logic [PIX_W-1:0]   frag_pix,
    input  logic [DEPTH_W-1:0] frag_depth,
    input  logic [COLOR_W-1:0] frag_color,
    input  logic               resolve_start,
    output logic               busy,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_pix,
    output logic [IDX_W-1:0]   out_rank,
    output logic [DEPTH_W-1:0] out_depth,
    output logic [COLOR_W-1:0] out_color,
    output logic               out_last,
    output logic               out_ovf
);
    frag_t            in_frag;
    logic [PIX_W-1:0] rd_pix;
    logic [CNT_W-1:0] rd_cnt;
    logic             rd_ovf;
    frag_t            rd_row [SLOTS];

    assign in_frag = '{depth: frag_depth, color: frag_color};

    fs_slot_store #(.NPIX(NPIX), .SLOTS(SLOTS)) u_store (
        .clk(clk), .rst(rst), .lock(busy), .clr(clr),
        .wr_valid(frag_valid), .wr_pix(frag_pix), .wr_frag(in_frag),
        .rd_pix(rd_pix), .rd_cnt(rd_cnt), .rd_ovf(rd_ovf), .rd_row(rd_row)
    );

    fs_resolver #(.NPIX(NPIX), .SLOTS(SLOTS)) u_resolve (
        .clk(clk), .rst(rst), .start(resolve_start),
        .rd_pix(rd_pix), .rd_cnt(rd_cnt), .rd_ovf(rd_ovf), .rd_row(rd_row),
        .busy(busy), .out_valid(out_valid), .out_pix(out_pix), .out_rank(out_rank),
        .out_depth(out_depth), .out_color(out_color), .out_last(out_last), .out_ovf(out_ovf)
    );

    AST_BEAT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy); // R8
endmodule

// File: tb/test_frag_sort_top.sv
module test_frag_sort_top;
    localparam int NPIX  = 16;
    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        frag_valid = 1'b0;
    logic [3:0]  frag_pix = '0;
    logic [15:0] frag_depth = '0;
    logic [15:0] frag_color = '0;
    logic        resolve_start = 1'b0;
    logic        busy, out_valid, out_last, out_ovf;
    logic [3:0]  out_pix;
    logic [1:0]  out_rank;
    logic [15:0] out_depth, out_color;

    always #2.5 clk = ~clk;

    frag_sort_top #(.NPIX(NPIX), .SLOTS(SLOTS)) i_frag_sort_top (
        .clk(clk), .rst(rst), .clr(clr), .frag_valid(frag_valid), .frag_pix(frag_pix),
        .frag_depth(frag_depth), .frag_color(frag_color), .resolve_start(resolve_start),
        .busy(busy), .out_valid(out_valid), .out_pix(out_pix), .out_rank(out_rank),
        .out_depth(out_depth), .out_color(out_color), .out_last(out_last), .out_ovf(out_ovf)
    );

    typedef struct {
        int pix; int rank; int d; int c; bit last; bit ovf;
    } beat_t;

    int    md [NPIX][$];
    int    mc [NPIX][$];
    bit    movf [NPIX];
    beat_t exp_q [$];
    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // reference: compare every output beat against the model's expected stream
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", $sformatf("unexpected beat pix=%0d rank=%0d, expected none",
                      out_pix, out_rank));
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(out_pix == 4'(e.pix) && out_rank == 2'(e.rank) &&
                      out_depth == 16'(e.d) && out_color == 16'(e.c) &&
                      out_last == e.last && out_ovf == e.ovf, "R5 R6 R7 R3",
                      $sformatf("actual pix=%0d rank=%0d d=%0h c=%0h last=%0b ovf=%0b expected pix=%0d rank=%0d d=%0h c=%0h last=%0b ovf=%0b",
                      out_pix, out_rank, out_depth, out_color, out_last, out_ovf,
                      e.pix, e.rank, e.d, e.c, e.last, e.ovf));
            end
        end
    end

    task automatic model_clear();
        for (int p = 0; p < NPIX; p++) begin
            md[p].delete(); mc[p].delete(); movf[p] = 1'b0;
        end
    endtask

    // one accepted fragment per call, back to back
    task automatic frag(input int p, input int d, input int c);
        @(negedge clk);
        frag_valid = 1'b1; frag_pix = 4'(p); frag_depth = 16'(d); frag_color = 16'(c);
        if (md[p].size() < SLOTS) begin
            md[p].push_back(d); mc[p].push_back(c);
        end else movf[p] = 1'b1;
    endtask

    task automatic quiet();
        @(negedge clk);
        frag_valid = 1'b0; clr = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        frag_valid = 1'b0; clr = 1'b1;
        model_clear();
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic build_expected();
        for (int p = 0; p < NPIX; p++) begin
            int sd[$]; int sc[$];
            sd = md[p]; sc = mc[p];
            for (int a = 1; a < sd.size(); a++) begin
                for (int b = a; b > 0 && sd[b-1] > sd[b]; b--) begin
                    int t;
                    t = sd[b]; sd[b] = sd[b-1]; sd[b-1] = t;
                    t = sc[b]; sc[b] = sc[b-1]; sc[b-1] = t;
                end
            end
            for (int r = 0; r < sd.size(); r++) begin
                beat_t e;
                e.pix = p; e.rank = r; e.d = sd[r]; e.c = sc[r];
                e.last = (r == sd.size() - 1); e.ovf = movf[p];
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic resolve(input bit inject, input string tag);
        int waited;
        build_expected();
        @(negedge clk);
        resolve_start = 1'b1;
        @(negedge clk);
        resolve_start = 1'b0;
        check(busy == 1'b1, "R8", $sformatf("%s busy=%0b expected 1", tag, busy));
        if (inject && busy) begin
            // R8: stimulus while busy must change nothing
            frag_valid = 1'b1; clr = 1'b1; frag_pix = 4'd3; frag_depth = 16'h0001; frag_color = 16'hDEAD;
            resolve_start = 1'b1;
            @(negedge clk);
            clr = 1'b0; resolve_start = 1'b0; frag_pix = 4'd9;
            @(negedge clk);
            frag_valid = 1'b0;
        end
        waited = 0;
        while (busy && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(!busy, "R8", $sformatf("%s busy=%0b after %0d cycles expected 0", tag, busy, waited));
        check(exp_q.size() == 0, "R4",
              $sformatf("%s beats missing: actual remaining=%0d expected 0", tag, exp_q.size()));
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(busy == 1'b0 && out_valid == 1'b0, "R10",
              $sformatf("busy=%0b out_valid=%0b expected 0 0", busy, out_valid));
        resolve(1'b0, "R10 empty after reset");

        // descending, ties, overflow, back-to-back same pixel (R2 R3 R6 R9)
        frag(5, 'h0900, 'h5001); frag(5, 'h0700, 'h5002); frag(5, 'h0500, 'h5003);
        frag(5, 'h0300, 'h5004); frag(5, 'h0100, 'h5005); frag(5, 'h0050, 'h5006);
        frag(0, 'h0040, 'h0001);
        frag(2, 'h0200, 'h2001); frag(7, 'h0010, 'h7001); frag(2, 'h0100, 'h2002);
        frag(2, 'h0200, 'h2003); frag(7, 'hFFFF, 'h7002); frag(2, 'h0100, 'h2004);
        frag(15, 'h1234, 'hF001); frag(15, 'h0000, 'hF002);
        quiet();
        resolve(1'b1, "R2 R3 R9 first resolve");
        // R8: the injected stimulus and the first readout left the lists intact
        resolve(1'b0, "R8 repeat resolve");

        // R1: clear empties everything, including the overflow mark
        do_clear();
        resolve(1'b0, "R1 after clear");

        // R1: clear wins over a fragment in the same cycle
        @(negedge clk);
        clr = 1'b1; frag_valid = 1'b1; frag_pix = 4'd4; frag_depth = 16'h0077; frag_color = 16'h4444;
        model_clear();
        quiet();

        // ascending, all-equal depths, pixel 5 no longer overflowed (R5 R6 R3)
        frag(1, 'h0001, 'h1001); frag(1, 'h0002, 'h1002); frag(1, 'h0003, 'h1003);
        frag(9, 'h0AAA, 'h9001); frag(9, 'h0AAA, 'h9002); frag(9, 'h0AAA, 'h9003);
        frag(9, 'h0AAA, 'h9004);
        frag(5, 'h0300, 'h5101); frag(5, 'h0100, 'h5102);
        frag(12, 'h0300, 'hC001); frag(12, 'h0100, 'hC002); frag(12, 'h0300, 'hC003);
        frag(12, 'h0100, 'hC004); frag(12, 'h0000, 'hC005);
        quiet();
        resolve(1'b0, "R5 R6 second pattern");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule